// File: doc/BRIEF.md
# ADC Readout and Audio Frame Sequencer

This block connects an on-chip successive-approximation converter to an audio processing chain, with everything on a single system clock. Each end-of-conversion pulse from the converter is turned, in the same cycle, into a read request on the converter's register-read port. The request always reads the same result register. The 16-bit word that comes back is captured on the data-ready handshake and presented downstream as a one-cycle sample pulse. The upper 12 bits of that word hold the conversion result and the lower 4 bits hold extra averaging bits. The word is passed through unchanged.

The block also divides the system clock into an audio-rate strobe. The default divide ratio is 1248: at a 60 MHz clock this gives about 48.077 kHz, and with a 78-clock conversion time it fits exactly 16 conversions in each audio period. A monitor counts conversions between strobes and raises a sticky alignment-error flag when a frame holds any other number. A read that is still waiting for its data blocks a new end-of-conversion from issuing a request, and each such dropped request is counted.

The sample output is a valid-only stream, and it has no back-pressure. The converter cannot be stalled, so the consumer must take every word in the cycle where `sample_valid` is high. `sample_data` then holds that word until the next capture.

Top module: `adc_frame_seq`

## Requirements
- R1: When no read is pending, `adc_den` equals `adc_eoc` in the same cycle, and `adc_daddr` is always the parameter `RD_ADDR` (default 0x03).
- R2: When `adc_drdy` is high while a read is pending, `sample_data` takes `adc_do` and `sample_valid` is high for exactly the next cycle.
- R3: When `adc_drdy` is high while no read is pending, nothing happens: `sample_valid` stays low and `sample_data` keeps its value.
- R4: An `adc_eoc` that arrives while a read is pending issues no request. It increments `overrun_count` by one, and `overrun_count` saturates at 2^`OVR_W`-1.
- R5: `audio_strobe` is high for one cycle each time the number of clock edges since reset, counted modulo `FRAME_DIV`, equals `FRAME_DIV`-1. It is low in every other cycle.
- R6: `align_error` goes high in the cycle after a strobe that closes a frame whose `adc_eoc` count differs from `CONV_PER_FRAME`. An end-of-conversion in a strobe cycle counts toward the next frame. The partial frame from reset to the first strobe is not judged.
- R7: Once `align_error` is set it stays set until reset, even when later frames are correct.
- R8: A synchronous active-high `rst` clears the strobe divider, the conversion count, the pending read, `sample_data`, `sample_valid`, `align_error` and `overrun_count`.
- R9: A data-ready that completes the pending read in the same cycle as a new `adc_eoc` lets that end-of-conversion issue a request, and no overrun is counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| adc_eoc | input | 1 | End-of-conversion pulse from the converter |
| adc_drdy | input | 1 | Read data valid from the converter register port |
| adc_do | input | DATA_W | Read data from the converter register port |
| adc_den | output | 1 | Read request to the converter register port |
| adc_daddr | output | ADDR_W | Read address, fixed to the result register |
| sample_data | output | DATA_W | Last captured result word |
| sample_valid | output | 1 | One-cycle pulse per captured word |
| audio_strobe | output | 1 | One-cycle audio-rate strobe |
| align_error | output | 1 | Sticky frame alignment error |
| overrun_count | output | OVR_W | Saturating count of dropped read requests |

## Verification
The bench builds the block with `FRAME_DIV`=96, `CONV_PER_FRAME`=8 and `OVR_W`=4, and drives a converter model with one end-of-conversion every 12 clocks. This keeps the ratio of the default configuration, and short frames let the bench push every 12-bit result code through the capture path in about 49k cycles. A 4-bit overrun counter reaches saturation within a few hundred cycles. Changing the converter's latency to 12 and then to 14 clocks exercises the same-cycle completion case and the dropped-request case. Changing its period to 13 clocks breaks frame alignment within two frames.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic {
    RD_IDLE = 1'b0,
    RD_WAIT = 1'b1
  } rd_state_e;

  function automatic int unsigned bits_for(input int unsigned max_value);
    return (max_value < 2) ? 1 : $clog2(max_value + 1);
  endfunction

endpackage

// File: rtl/adc_read_ctrl.sv
module adc_read_ctrl
  import adc_seq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int OVR_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              eoc,
  input  logic              drdy,
  input  logic [DATA_W-1:0] din,
  output logic              den,
  output logic [DATA_W-1:0] cap_data,
  output logic              cap_valid,
  output logic [OVR_W-1:0]  ovr_cnt
);

  localparam logic [OVR_W-1:0] OVR_MAX = '1;

  rd_state_e st_q, st_d;
  logic      busy;
  logic      drop;
  logic      take;

  // a read is busy only until its data-ready arrives; the completing
  // cycle already accepts a new request
  always_comb begin
    busy = (st_q == RD_WAIT) && !drdy;
    den  = eoc && !busy;
    drop = eoc && busy;
    take = drdy && (st_q == RD_WAIT);
    st_d = st_q;
    if (den) begin
      st_d = RD_WAIT;
    end else if (take) begin
      st_d = RD_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= RD_IDLE;
      cap_data  <= '0;
      cap_valid <= 1'b0;
      ovr_cnt   <= '0;
    end else begin
      st_q      <= st_d;
      cap_valid <= take;
      if (take) begin
        cap_data <= din;
      end
      if (drop && (ovr_cnt != OVR_MAX)) begin
        ovr_cnt <= ovr_cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/audio_strobe_gen.sv
module audio_strobe_gen #(
  parameter int FRAME_DIV = 1248
) (
  input  logic clk,
  input  logic rst,
  output logic strobe
);

  localparam int unsigned    CW   = adc_seq_pkg::bits_for(FRAME_DIV - 1);
  localparam logic [CW-1:0]  LAST = CW'(FRAME_DIV - 1);

  logic [CW-1:0] div_q;

  assign strobe = (div_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q <= '0;
    end else if (strobe) begin
      div_q <= '0;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end

endmodule

// File: rtl/frame_align_mon.sv
module frame_align_mon #(
  parameter int CONV_PER_FRAME = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic strobe,
  input  logic eoc,
  output logic align_error
);

  // one count above the target is enough to tell "too many"
  localparam int unsigned   CNT_MAX = CONV_PER_FRAME + 1;
  localparam int unsigned   CW      = adc_seq_pkg::bits_for(CNT_MAX);
  localparam logic [CW-1:0] TARGET  = CW'(CONV_PER_FRAME);
  localparam logic [CW-1:0] SAT     = CW'(CNT_MAX);

  logic [CW-1:0] conv_q;
  logic          judged_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      conv_q      <= '0;
      judged_q    <= 1'b0;
      align_error <= 1'b0;
    end else if (strobe) begin
      if (judged_q && (conv_q != TARGET)) begin
        align_error <= 1'b1;
      end
      judged_q <= 1'b1;
      conv_q   <= eoc ? CW'(1) : '0;
    end else if (eoc && (conv_q != SAT)) begin
      conv_q <= conv_q + 1'b1;
    end
  end

endmodule

// File: rtl/adc_frame_seq.sv
module adc_frame_seq #(
  parameter int                DATA_W         = 16,
  parameter int                ADDR_W         = 8,
  parameter logic [ADDR_W-1:0] RD_ADDR        = 8'h03,
  parameter int                FRAME_DIV      = 1248,
  parameter int                CONV_PER_FRAME = 16,
  parameter int                OVR_W          = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adc_eoc,
  input  logic              adc_drdy,
  input  logic [DATA_W-1:0] adc_do,
  output logic              adc_den,
  output logic [ADDR_W-1:0] adc_daddr,
  output logic [DATA_W-1:0] sample_data,
  output logic              sample_valid,
  output logic              audio_strobe,
  output logic              align_error,
  output logic [OVR_W-1:0]  overrun_count
);

  assign adc_daddr = RD_ADDR;

  adc_read_ctrl #(
    .DATA_W (DATA_W),
    .OVR_W  (OVR_W)
  ) u_rd (
    .clk       (clk),
    .rst       (rst),
    .eoc       (adc_eoc),
    .drdy      (adc_drdy),
    .din       (adc_do),
    .den       (adc_den),
    .cap_data  (sample_data),
    .cap_valid (sample_valid),
    .ovr_cnt   (overrun_count)
  );

  audio_strobe_gen #(
    .FRAME_DIV (FRAME_DIV)
  ) u_div (
    .clk    (clk),
    .rst    (rst),
    .strobe (audio_strobe)
  );

  frame_align_mon #(
    .CONV_PER_FRAME (CONV_PER_FRAME)
  ) u_mon (
    .clk         (clk),
    .rst         (rst),
    .strobe      (audio_strobe),
    .eoc         (adc_eoc),
    .align_error (align_error)
  );

endmodule

// File: rtl/adc_frame_seq_chk.sv
module adc_frame_seq_chk #(
  parameter int DATA_W = 16,
  parameter int OVR_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              adc_eoc,
  input logic              adc_drdy,
  input logic              adc_den,
  input logic [DATA_W-1:0] sample_data,
  input logic              sample_valid,
  input logic              audio_strobe,
  input logic              align_error,
  input logic [OVR_W-1:0]  overrun_count
);

  localparam logic [OVR_W-1:0] OVR_MAX = '1;

  assert_den_needs_eoc_R1: assert property (@(posedge clk) disable iff (rst)
    adc_den |-> adc_eoc);

  assert_valid_follows_drdy_R2: assert property (@(posedge clk) disable iff (rst)
    sample_valid |-> $past(adc_drdy));

  assert_data_held_R3: assert property (@(posedge clk) disable iff (rst)
    !sample_valid |-> $stable(sample_data));

  assert_overrun_step_R4: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (overrun_count == $past(overrun_count)) ||
             (overrun_count == $past(overrun_count) + 1'b1));

  assert_overrun_saturates_R4: assert property (@(posedge clk) disable iff (rst)
    (overrun_count == OVR_MAX) |=> (overrun_count == OVR_MAX));

  assert_strobe_single_R5: assert property (@(posedge clk) disable iff (rst)
    audio_strobe |=> !audio_strobe);

  assert_error_after_strobe_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(align_error) |-> $past(audio_strobe));

  assert_error_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    align_error |=> align_error);

endmodule

bind adc_frame_seq adc_frame_seq_chk #(
  .DATA_W (DATA_W),
  .OVR_W  (OVR_W)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .adc_eoc       (adc_eoc),
  .adc_drdy      (adc_drdy),
  .adc_den       (adc_den),
  .sample_data   (sample_data),
  .sample_valid  (sample_valid),
  .audio_strobe  (audio_strobe),
  .align_error   (align_error),
  .overrun_count (overrun_count)
);

// File: tb/tb_adc_frame_seq.sv
`timescale 1ns/1ps
module tb_adc_frame_seq;

  localparam int DIV   = 96;
  localparam int CONV  = 8;
  localparam int OW    = 4;
  localparam int OVMAX = 15;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        adc_eoc = 1'b0;
  logic        adc_drdy = 1'b0;
  logic [15:0] adc_do = '0;
  logic        adc_den;
  logic [7:0]  adc_daddr;
  logic [15:0] sample_data;
  logic        sample_valid;
  logic        audio_strobe;
  logic        align_error;
  logic [OW-1:0] overrun_count;

  always #2.5 clk = ~clk;

  adc_frame_seq #(
    .DATA_W (16), .ADDR_W (8), .RD_ADDR (8'h03),
    .FRAME_DIV (DIV), .CONV_PER_FRAME (CONV), .OVR_W (OW)
  ) dut (
    .clk (clk), .rst (rst), .adc_eoc (adc_eoc), .adc_drdy (adc_drdy),
    .adc_do (adc_do), .adc_den (adc_den), .adc_daddr (adc_daddr),
    .sample_data (sample_data), .sample_valid (sample_valid),
    .audio_strobe (audio_strobe), .align_error (align_error),
    .overrun_count (overrun_count)
  );

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  // edges seen with reset low, the bench's own divider reference
  int n_edges = 0;
  always @(posedge clk) n_edges <= rst ? 0 : n_edges + 1;

  // converter model controls
  bit model_on  = 0;
  bit stray_req = 0;
  int period    = 12;
  int lat       = 2;
  int ph        = 0;
  int rd_due    = 0;
  int reads     = 0;
  int ovr_exp   = 0;
  logic [15:0] cur_word = '0;
  logic [15:0] data_exp = '0;
  bit last_real  = 0;
  bit last_stray = 0;
  bit ovr_evt    = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] word_of(input int k);
    logic [11:0] kk;
    kk = 12'(k);
    return {kk, kk[3:0] ^ 4'hA};
  endfunction

  // converter model and cycle checks, all at the falling edge
  initial begin
    forever begin
      bit exp_strobe;
      bit drdy_now;
      @(negedge clk);
      exp_strobe = ((n_edges % DIV) == DIV - 1);
      if (exp_strobe || audio_strobe)
        chk(audio_strobe == exp_strobe, "R5 strobe", 32'(audio_strobe), 32'(exp_strobe));
      if (last_real || sample_valid) begin
        chk(sample_valid == last_real, "R2 valid", 32'(sample_valid), 32'(last_real));
        if (last_real) chk(sample_data == data_exp, "R2 data", 32'(sample_data), 32'(data_exp));
      end
      if (last_stray)
        chk(!sample_valid && sample_data == data_exp, "R3 stray drdy ignored",
            {15'd0, sample_valid, sample_data}, {16'd0, data_exp});
      if (ovr_evt) chk(overrun_count == OW'(ovr_exp), "R4 overrun", 32'(overrun_count), 32'(ovr_exp));
      last_real = 0; last_stray = 0; ovr_evt = 0; drdy_now = 0;
      adc_eoc = 1'b0; adc_drdy = 1'b0;
      if (rd_due == 1) begin
        adc_drdy = 1'b1; adc_do = cur_word; data_exp = cur_word;
        last_real = 1; drdy_now = 1;
      end else if (rd_due == 0 && stray_req) begin
        adc_drdy = 1'b1; adc_do = 16'hDEAD; stray_req = 0; last_stray = 1;
      end
      if (rd_due > 0) rd_due--;
      if (model_on) begin
        if (ph == 0) adc_eoc = 1'b1;
        ph = (ph + 1) % period;
      end
      #1;
      if (adc_eoc) begin
        if (rd_due == 0) begin
          chk(adc_den && adc_daddr == 8'h03, drdy_now ? "R9 same-cycle reissue" : "R1 request",
              {23'd0, adc_den, adc_daddr}, {23'd1, 8'h03});
          cur_word = word_of(reads);
          reads++;
          rd_due = lat;
        end else begin
          chk(!adc_den, "R4 dropped request", 32'(adc_den), 32'd0);
          if (ovr_exp < OVMAX) ovr_exp++;
          ovr_evt = 1;
        end
      end
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    model_on = 0;
    while (rd_due != 0) @(negedge clk);
    wait_cyc(2);
    rst = 1'b1;
    wait_cyc(3);
    chk(!sample_valid && sample_data == 16'd0, "R8 sample cleared", {15'd0, sample_valid, sample_data}, 32'd0);
    chk(!align_error && overrun_count == '0, "R8 flags cleared", {27'd0, align_error, overrun_count}, 32'd0);
    chk(!audio_strobe && !adc_den, "R8 strobe and request low", {30'd0, audio_strobe, adc_den}, 32'd0);
    data_exp = '0; ovr_exp = 0;
    rst = 1'b0;
  endtask

  initial begin
    wait_cyc(4);
    do_reset();
    // partial first frame: converter starts late
    wait_cyc(40);
    ph = 0; period = 12; lat = 2;
    model_on = 1;
    // near-exhaustive sweep of all 12-bit result codes
    while (reads < 4096) @(negedge clk);
    chk(align_error == 1'b0, "R6 aligned frames and exempt first frame", 32'(align_error), 32'd0);
    chk(overrun_count == '0, "R4 no overrun at latency 2", 32'(overrun_count), 32'd0);
    // stray data-ready pulses with nothing pending
    for (int i = 0; i < 20; i++) begin
      wait_cyc(7);
      stray_req = 1;
    end
    wait_cyc(20);
    // completion coinciding with the next end-of-conversion
    lat = 12;
    wait_cyc(300);
    chk(overrun_count == '0, "R9 no overrun on same-cycle completion", 32'(overrun_count), 32'd0);
    // late data: every other end-of-conversion is dropped
    lat = 14;
    wait_cyc(500);
    chk(overrun_count == OW'(OVMAX), "R4 saturation", 32'(overrun_count), 32'(OVMAX));
    chk(align_error == 1'b0, "R6 no error before misalignment", 32'(align_error), 32'd0);
    // misaligned converter
    lat = 2;
    period = 13;
    wait_cyc(3 * DIV);
    chk(align_error == 1'b1, "R6 misaligned frame flagged", 32'(align_error), 32'd1);
    period = 12;
    ph = ph % 12;
    wait_cyc(3 * DIV);
    chk(align_error == 1'b1, "R7 error stays set", 32'(align_error), 32'd1);
    do_reset();
    wait_cyc(DIV + 10);
    chk(align_error == 1'b0, "R7 cleared by reset", 32'(align_error), 32'd0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule